// File: doc/BRIEF.md
# Edge-Timestamping Interval Timer

This block is a 16-bit up-counter with a timestamp mode for an asynchronous comparator output. The count advances on a selectable enable: every system clock, one system clock in twelve, or one in eight rising edges of a slow external clock. Counting happens only while the run bit is set. With timestamp mode on and the split-byte mode off, each rising comparator edge copies the live count into the 16-bit reload register and raises the high overflow flag. That flag can drive an interrupt.

Software finds the period of the comparator signal by subtracting two successive timestamps. The result is in timer ticks. The comparator path passes through a fixed-latency synchronizer, so every edge is delayed by the same number of cycles and the subtraction stays exact. Without timestamp mode the block is an ordinary timer: either one 16-bit auto-reload counter, or two independent 8-bit auto-reload counters in split mode. A byte-wide register port sets the mode and gives access to the count, the reload value and the flags.

Top module: `edge_capture_timer`

## Requirements
- R1: A comparator rising edge loads the reload register only when the timestamp bit (CTRL bit 1) is 1 and the split bit (CTRL bit 2) is 0. Otherwise comparator edges leave the reload register unchanged.
- R2: Each rising edge of the comparator produces exactly one timestamp. A level held high and a falling edge produce none.
- R3: A timestamp stores all 16 count bits into the reload register, read as low byte at address 3 and high byte at address 4. The count is read at addresses 1 (low) and 2 (high). With the counter stopped, the stored value equals the value written to the count.
- R4: A timestamp sets the high flag (CTRL bit 7). The irq output is 1 whenever the interrupt-enable bit (CTRL bit 5) is 1 and either flag is set.
- R5: With CTRL bit 3 = 1 the count advances every clock. With bit 3 = 0 and bit 4 = 0 it advances once every 12 clocks. With bit 3 = 0 and bit 4 = 1 it advances once per 8 rising edges of ext_clk.
- R6: The count changes only while the run bit (CTRL bit 0) is 1, apart from register writes.
- R7: The difference of two successive timestamps equals the number of timer ticks between the two comparator rising edges.
- R8: In timestamp mode the count wraps from 0xFFFF to 0x0000 without reloading and sets the high flag. The reload register keeps its value.
- R9: In 16-bit mode without timestamping, the count that passes 0xFFFF loads the reload value and sets the high flag.
- R10: A flag is cleared only by a CTRL write with 0 in its bit position. A 1 in that position leaves it unchanged. A clear in the same cycle as a timestamp leaves the high flag set.
- R11: Reset clears CTRL, the count, the reload register, both flags and irq.
- R12: In split mode the low and high count bytes each advance on the tick and each reload from their own reload byte on passing 0xFF. The low byte sets the low flag (CTRL bit 6) and the high byte sets the high flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cmp_in | input | 1 | Asynchronous comparator output |
| ext_clk | input | 1 | Asynchronous slow external clock |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check the following:
- a timestamp copies the previous count and sets the flag;
- the flag holds until it is cleared;
- a stopped counter and a disabled timestamp path stay frozen;
- the wrap and reload on overflow;
- single-cycle edge and prescaler pulses;
- the interrupt that follows a timestamp.

Only the bench scenarios can show the following:
- that the difference of two timestamps matches the real edge spacing under each tick source;
- that a long high level yields one timestamp;
- the exact reset values;
- the split-byte behaviour seen at the register port.

// File: rtl/ect_pkg.sv
package ect_pkg;
   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_CNT_LO = 3'd1;
   localparam logic [2:0] A_CNT_HI = 3'd2;
   localparam logic [2:0] A_RLD_LO = 3'd3;
   localparam logic [2:0] A_RLD_HI = 3'd4;

   localparam int B_FLAG_LO = 6;
   localparam int B_FLAG_HI = 7;

   // stored control bits, bit 5 down to bit 0
   typedef struct packed {
      logic ie;
      logic ext;
      logic fast;
      logic split;
      logic cap;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ect_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;

   // R2: a rising edge yields a pulse of exactly one cycle
   p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/ect_prescale.sv
module ect_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("ect_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = step;
   end else begin : g_count
      localparam int W = $clog2(DIV);
      logic [W-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            phase <= '0;
         else if (step)
            phase <= (phase == W'(DIV - 1)) ? '0 : phase + W'(1);
      end

      assign tick = step && (phase == W'(DIV - 1));

      // R5: a divided tick never lasts two cycles
      p_tick_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/ect_count_core.sv
module ect_count_core #(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic                  split,
   input  logic                  cap_mode,
   input  logic                  cap_pulse,
   input  logic [1:0]            wr_cnt,
   input  logic [1:0]            wr_rld,
   input  logic [BYTE_W-1:0]     wdata,
   input  logic                  clr_lo,
   input  logic                  clr_hi,
   output logic [2*BYTE_W-1:0]   cnt,
   output logic [2*BYTE_W-1:0]   rld,
   output logic                  flag_lo,
   output logic                  flag_hi
);
   localparam int CW = 2 * BYTE_W;

   logic [CW-1:0] cnt_nx;
   logic          ovf_lo, ovf_hi;
   logic          cap_hit;

   assign cap_hit = cap_mode & cap_pulse;

   always_comb begin
      cnt_nx = cnt;
      ovf_lo = 1'b0;
      ovf_hi = 1'b0;
      if (adv) begin
         if (split) begin
            if (cnt[BYTE_W-1:0] == '1) begin
               cnt_nx[BYTE_W-1:0] = rld[BYTE_W-1:0];
               ovf_lo = 1'b1;
            end else begin
               cnt_nx[BYTE_W-1:0] = cnt[BYTE_W-1:0] + BYTE_W'(1);
            end
            if (cnt[CW-1:BYTE_W] == '1) begin
               cnt_nx[CW-1:BYTE_W] = rld[CW-1:BYTE_W];
               ovf_hi = 1'b1;
            end else begin
               cnt_nx[CW-1:BYTE_W] = cnt[CW-1:BYTE_W] + BYTE_W'(1);
            end
         end else if (cnt == '1) begin
            cnt_nx = cap_mode ? '0 : rld;
            ovf_hi = 1'b1;
         end else begin
            cnt_nx = cnt + CW'(1);
         end
      end
      if (wr_cnt[0]) cnt_nx[BYTE_W-1:0]  = wdata;
      if (wr_cnt[1]) cnt_nx[CW-1:BYTE_W] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rld     <= '0;
         flag_lo <= 1'b0;
         flag_hi <= 1'b0;
      end else begin
         cnt <= cnt_nx;
         if (cap_hit) begin
            rld <= cnt;
         end else begin
            if (wr_rld[0]) rld[BYTE_W-1:0]  <= wdata;
            if (wr_rld[1]) rld[CW-1:BYTE_W] <= wdata;
         end
         if (ovf_lo)      flag_lo <= 1'b1;
         else if (clr_lo) flag_lo <= 1'b0;
         if (ovf_hi || cap_hit) flag_hi <= 1'b1;
         else if (clr_hi)       flag_hi <= 1'b0;
      end
   end

   // R3: the timestamp holds the count of the edge cycle
   p_cap_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> rld == $past(cnt));
   // R4: a timestamp raises the high flag
   p_cap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> flag_hi);
   // R10: the high flag falls only on a clear
   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_hi && !clr_hi |=> flag_hi);
   // R6: no advance and no write leaves the count frozen
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv && wr_cnt == 2'b00 |=> $stable(cnt));
   // R1: without timestamp mode only writes touch the reload register
   p_no_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_mode && wr_rld == 2'b00 |=> $stable(rld));
   // R8: timestamp mode wraps to zero
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode && !split && adv && cnt == '1 && wr_cnt == 2'b00 |=> cnt == '0);
   // R9: plain 16-bit mode reloads on overflow
   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_mode && !split && adv && cnt == '1 && wr_cnt == 2'b00
      |=> cnt == $past(rld) && flag_hi);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
   parameter int BYTE_W      = 8,
   parameter int SYS_DIV     = 12,
   parameter int EXT_DIV     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              cmp_in,
   input  logic              ext_clk,
   output logic              irq
);
   import ect_pkg::*;

   localparam int CW = 2 * BYTE_W;

   if (BYTE_W < 8) begin : g_bad_width
      $error("edge_capture_timer: BYTE_W must be at least 8");
   end

   ctrl_t         ctrl;
   logic          ctrl_wr;
   logic          cap_rise, ext_rise;
   logic          tick_sys, tick_ext, tick, adv;
   logic          cap_mode;
   logic [CW-1:0] cnt, rld;
   logic          flag_lo, flag_hi;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= '0;
      else if (ctrl_wr) ctrl <= ctrl_t'(wr_data[5:0]);
   end

   ect_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cap_rise));

   ect_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise));

   ect_prescale #(.DIV(SYS_DIV)) u_div_sys (
      .clk(clk), .rst_n(rst_n), .step(1'b1), .tick(tick_sys));

   ect_prescale #(.DIV(EXT_DIV)) u_div_ext (
      .clk(clk), .rst_n(rst_n), .step(ext_rise), .tick(tick_ext));

   assign tick     = ctrl.fast ? 1'b1 : (ctrl.ext ? tick_ext : tick_sys);
   assign adv      = ctrl.run & tick;
   assign cap_mode = ctrl.cap & ~ctrl.split;

   ect_count_core #(.BYTE_W(BYTE_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .adv(adv), .split(ctrl.split), .cap_mode(cap_mode), .cap_pulse(cap_rise),
      .wr_cnt({wr_en && wr_addr == A_CNT_HI, wr_en && wr_addr == A_CNT_LO}),
      .wr_rld({wr_en && wr_addr == A_RLD_HI, wr_en && wr_addr == A_RLD_LO}),
      .wdata(wr_data),
      .clr_lo(ctrl_wr && !wr_data[B_FLAG_LO]),
      .clr_hi(ctrl_wr && !wr_data[B_FLAG_HI]),
      .cnt(cnt), .rld(rld), .flag_lo(flag_lo), .flag_hi(flag_hi));

   assign irq = ctrl.ie & (flag_hi | flag_lo);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL:   rd_data[7:0] = {flag_hi, flag_lo, ctrl};
         A_CNT_LO: rd_data = cnt[BYTE_W-1:0];
         A_CNT_HI: rd_data = cnt[CW-1:BYTE_W];
         A_RLD_LO: rd_data = rld[BYTE_W-1:0];
         A_RLD_HI: rd_data = rld[CW-1:BYTE_W];
         default:  rd_data = '0;
      endcase
   end

   // R4: a timestamp with interrupts enabled requests an interrupt
   p_cap_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode && cap_rise && ctrl.ie && !ctrl_wr |=> irq);
   // R1: split mode never counts as timestamp mode
   p_split_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.split |-> !cap_mode);
endmodule

// File: tb/sim_edge_capture_timer.sv
module sim_edge_capture_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       cmp_in = 1'b0;
   logic       ext_clk = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   edge_capture_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cmp_in(cmp_in), .ext_clk(ext_clk), .irq(irq));

   always #5 clk = ~clk;
   always #20 ext_clk = ~ext_clk;

   localparam int NV = 5;
   localparam logic        V_FAST [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam logic        V_EXT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam int          V_GAP  [NV] = '{37, 100, 120, 240, 320};
   localparam logic [15:0] V_DIFF [NV] = '{16'd37, 16'd100, 16'd10, 16'd20, 16'd10};

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd8(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic rd16(input logic [2:0] alo, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd8(alo, lo);
      rd8(alo + 3'd1, hi);
      v = {hi, lo};
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_cmp();
      @(negedge clk);
      cmp_in = 1'b1;
      repeat (3) @(negedge clk);
      cmp_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, r1, r2;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd8(3'd0, b);   chk({8'h0, b}, 16'h0000, "R11 ctrl");
      rd16(3'd1, v);  chk(v, 16'h0000, "R11 count");
      rd16(3'd3, v);  chk(v, 16'h0000, "R11 reload");
      chk({15'h0, irq}, 16'h0000, "R11 irq");

      // R3 R6: stopped counter, timestamp copies the written count
      wr(3'd0, 8'h0A);
      wr(3'd1, 8'h34);
      wr(3'd2, 8'h12);
      pulse_cmp();
      rd16(3'd3, v);  chk(v, 16'h1234, "R3 stamp of stopped count");
      rd16(3'd1, v);  chk(v, 16'h1234, "R6 count held with run off");
      rd8(3'd0, b);   chk({8'h0, b}, 16'h008A, "R4 flag set by stamp");
      chk({15'h0, irq}, 16'h0000, "R4 irq masked");

      // R10: clear coinciding with a timestamp keeps the flag
      @(negedge clk); cmp_in = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h0A;
      @(negedge clk); wr_en = 1'b0;
      cmp_in = 1'b0;
      rd8(3'd0, b);   chk({8'h0, b}, 16'h008A, "R10 clear loses to stamp");
      repeat (4) @(negedge clk);
      wr(3'd0, 8'h0A);
      rd8(3'd0, b);   chk({8'h0, b}, 16'h000A, "R10 clear by zero write");

      // R1: split or timestamp-off ignores comparator edges
      wr(3'd0, 8'h0F);
      pulse_cmp();
      rd16(3'd3, v);  chk(v, 16'h1234, "R1 split blocks stamp");
      wr(3'd0, 8'h09);
      pulse_cmp();
      rd16(3'd3, v);  chk(v, 16'h1234, "R1 stamp bit off");

      // R9: 16-bit reload on overflow
      wr(3'd0, 8'h08);
      wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
      wr(3'd3, 8'hF0); wr(3'd4, 8'hFF);
      wr(3'd0, 8'hC9);
      repeat (1) @(negedge clk);
      wr(3'd0, 8'hC8);
      rd16(3'd1, v);  chk(v, 16'hFFF1, "R9 reload after overflow");
      rd8(3'd0, b);   chk({8'h0, b}, 16'h0088, "R9 flag on overflow");

      // R8: timestamp mode wraps to zero, reload untouched
      wr(3'd0, 8'h0A);
      wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
      wr(3'd0, 8'hCB);
      repeat (1) @(negedge clk);
      wr(3'd0, 8'hCA);
      rd16(3'd1, v);  chk(v, 16'h0001, "R8 wrap to zero");
      rd16(3'd3, v);  chk(v, 16'hFFF0, "R8 reload kept");
      rd8(3'd0, b);   chk({8'h0, b}, 16'h008A, "R8 flag on wrap");

      // R12: split bytes reload independently
      wr(3'd0, 8'h0C);
      wr(3'd1, 8'hFE); wr(3'd2, 8'h10);
      wr(3'd3, 8'hF0);
      wr(3'd0, 8'hCD);
      repeat (1) @(negedge clk);
      wr(3'd0, 8'hCC);
      rd16(3'd1, v);  chk(v, 16'h13F1, "R12 split counts");
      rd8(3'd0, b);   chk({8'h0, b}, 16'h004C, "R12 low flag only");

      // R2: long high level gives one stamp
      wr(3'd0, 8'h0B);
      @(negedge clk); cmp_in = 1'b1;
      repeat (6) @(negedge clk);
      rd16(3'd3, r1);
      repeat (40) @(negedge clk);
      rd16(3'd3, r2);
      chk(r2, r1, "R2 single stamp per edge");
      cmp_in = 1'b0;
      repeat (6) @(negedge clk);

      // R5 R7 R4: table of tick sources and edge spacings
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, 8'h23 | {4'h0, V_FAST[i], 3'h0} | {3'h0, V_EXT[i], 4'h0});
         pulse_cmp();
         rd16(3'd3, r1);
         repeat (V_GAP[i] - 7) @(negedge clk);
         pulse_cmp();
         rd16(3'd3, r2);
         chk(r2 - r1, V_DIFF[i], $sformatf("R7 R5 interval vector %0d", i));
         chk({15'h0, irq}, 16'h0001, $sformatf("R4 irq vector %0d", i));
      end
      wr(3'd0, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule